// File: doc/BRIEF.md
# Dual Omega Operand Routing Network

This block carries word-wide results from a row of functional units back to the operand inputs of the same row. It holds two identical multistage Omega networks built from radix-4 switches. One network supplies every unit's first operand (operand A) and the other supplies every unit's second operand (operand B). Each switch output picks any of its four inputs, so one input can feed several outputs of the same switch in one cycle (multicast).

Routing is controlled by a context memory. Each context holds one 2-bit select for every switch output in every stage of both networks. While the run enable is high, a context counter steps through contexts 0 to II-1 and then returns to 0. II is the programmable initiation interval. The contexts and II are written one field at a time, and only while the run enable is low. The operand outputs are registered, so a value crosses from a producing unit to a consuming unit in exactly one clock.

With 16 ports the network has two stages. Stage 0 inputs are the unit result ports in order. Between the stages, output port p of stage 0 drives input port (p mod 4)*4 + p/4 of stage 1. Output port p of the last stage drives unit p.

Top module: `dual_omega_router`

## Requirements
- R1: While reset is asserted and right after it, both operand outputs are zero and `cur_ctx` is 0. Every stored select is 0 and the stored II is 1.
- R2: Each stage holds NPORT/4 switches. Output j of switch s drives port 4s+j and takes switch input port 4s+sel, where sel is the 2-bit select value of that output (0..3).
- R3: Stage 0 inputs are the result ports in order. Stage k output p drives stage k+1 input (p mod 4)*(NPORT/4)+p/4. Last-stage output p is the operand for unit p.
- R4: Outputs of one switch that hold equal select values all carry the same input word in the same cycle (multicast).
- R5: `opa_data` comes only from network 0 selects (`cfg_net`=0) and `opb_data` comes only from network 1 selects (`cfg_net`=1). The two networks are configured independently.
- R6: Operands registered at a clock edge come from the `fu_res` value and the active context present in the cycle before that edge.
- R7: While `run_en` is high, `cur_ctx` advances by one per clock and wraps from II-1 to 0. A clock with `run_en` low sets it to 0.
- R8: A written II of 0 acts as 1. A written II above MAXCTX acts as MAXCTX.
- R9: Select writes (`cfg_we`) and II writes (`ii_we`) are ignored while `run_en` is high.
- R10: A select write with `run_en` low lands at a clock edge and steers the operands registered at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Steps the context counter; blocks configuration writes |
| cfg_we | input | 1 | Write one select field |
| cfg_ctx | input | 3 | Context index of the select write |
| cfg_net | input | 1 | Network of the write: 0 = operand A, 1 = operand B |
| cfg_stage | input | 1 | Stage of the write |
| cfg_port | input | 4 | Switch output port of the write |
| cfg_sel | input | 2 | Select value: local switch input 0..3 |
| ii_we | input | 1 | Write the initiation interval |
| ii_val | input | 4 | Initiation interval value |
| fu_res | input | 256 | Unit results, port p in bits p*16 +: 16 |
| opa_data | output | 256 | First operands, unit p in bits p*16 +: 16 |
| opb_data | output | 256 | Second operands, unit p in bits p*16 +: 16 |
| cur_ctx | output | 3 | Context that steers the current routing |

## Verification
A corrupted select field, a miswired shuffle or a swapped network shows up as a wrong word on an operand output at the first edge after that context is used with distinct result words on every port. The bench therefore drives fresh random words on all ports in every cycle. A faulty context counter or II register shows on `cur_ctx` at the edge after the error. It also shows on the operands one cycle later, when the wrong context steers them. An ignored-write fault is visible within one run loop of II cycles.

// File: rtl/dor_pkg.sv
package dor_pkg;
  localparam int SELW = 2;

  // radix-4 perfect shuffle between adjacent stages
  function automatic int shuf4(input int p, input int n);
    return (p % 4) * (n / 4) + p / 4;
  endfunction
endpackage

// File: rtl/dor_switch4.sv
module dor_switch4 #(
  parameter int DW = 16
) (
  input  logic [4*DW-1:0] sw_in,
  input  logic [7:0]      sw_sel,
  output logic [4*DW-1:0] sw_out
);
  always_comb begin
    for (int j = 0; j < 4; j++) begin
      sw_out[j*DW +: DW] = sw_in[sw_sel[j*2 +: 2]*DW +: DW];
    end
  end
endmodule

// File: rtl/dor_omega.sv
module dor_omega #(
  parameter int DW     = 16,
  parameter int NPORT  = 16,
  parameter int STAGES = 2
) (
  input  logic [NPORT*DW-1:0]        net_in,
  input  logic [STAGES*NPORT*2-1:0]  net_sel,
  output logic [NPORT*DW-1:0]        net_out
);
  import dor_pkg::*;
  localparam int NSW = NPORT / 4;

  logic [STAGES-1:0][NPORT*DW-1:0] lvl_in;
  logic [STAGES-1:0][NPORT*DW-1:0] lvl_out;

  assign lvl_in[0] = net_in;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    for (genvar s = 0; s < NSW; s++) begin : g_sw
      dor_switch4 #(.DW(DW)) u_sw (
        .sw_in  (lvl_in[k][s*4*DW +: 4*DW]),
        .sw_sel (net_sel[(k*NPORT + s*4)*2 +: 8]),
        .sw_out (lvl_out[k][s*4*DW +: 4*DW])
      );
    end
    if (k < STAGES - 1) begin : g_link
      for (genvar p = 0; p < NPORT; p++) begin : g_wire
        assign lvl_in[k+1][shuf4(p, NPORT)*DW +: DW] = lvl_out[k][p*DW +: DW];
      end
    end
  end

  assign net_out = lvl_out[STAGES-1];
endmodule

// File: rtl/dor_ctx_seq.sv
module dor_ctx_seq #(
  parameter int NPORT  = 16,
  parameter int STAGES = 2,
  parameter int MAXCTX = 8,
  parameter int CTXW   = 3,
  parameter int STW    = 1,
  parameter int PW     = 4,
  parameter int IIW    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run_en,
  input  logic                       cfg_we,
  input  logic [CTXW-1:0]            cfg_ctx,
  input  logic                       cfg_net,
  input  logic [STW-1:0]             cfg_stage,
  input  logic [PW-1:0]              cfg_port,
  input  logic [1:0]                 cfg_sel,
  input  logic                       ii_we,
  input  logic [IIW-1:0]             ii_val,
  output logic [STAGES*NPORT*2-1:0]  sel_a,
  output logic [STAGES*NPORT*2-1:0]  sel_b,
  output logic [CTXW-1:0]            ctx_q,
  output logic [IIW-1:0]             ii_eff
);
  localparam int NPS = STAGES * NPORT;
  localparam int NF  = 2 * NPS;
  localparam int NMEM = MAXCTX * NF;

  logic [1:0]      sel_mem [NMEM];
  logic [IIW-1:0]  ii_q, ii_d;
  logic [CTXW-1:0] ctx_d, ctx_last;
  logic            wr_ok, ii_ok;
  int              wr_idx;

  assign wr_ok  = cfg_we && !run_en && (int'(cfg_stage) < STAGES)
                  && (int'(cfg_ctx) < MAXCTX);
  assign ii_ok  = ii_we && !run_en;
  assign wr_idx = int'(cfg_ctx) * NF + int'(cfg_net) * NPS
                  + int'(cfg_stage) * NPORT + int'(cfg_port);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NMEM; i++) sel_mem[i] <= '0;
    end else if (wr_ok) begin
      sel_mem[wr_idx] <= cfg_sel;
    end
  end

  always_comb begin
    for (int f = 0; f < NPS; f++) begin
      sel_a[f*2 +: 2] = sel_mem[int'(ctx_q) * NF + f];
      sel_b[f*2 +: 2] = sel_mem[int'(ctx_q) * NF + NPS + f];
    end
  end

  // effective interval: 0 acts as 1, clamp at MAXCTX
  always_comb begin
    if (ii_q == '0)                    ii_eff = IIW'(1);
    else if (int'(ii_q) > MAXCTX)      ii_eff = IIW'(MAXCTX);
    else                               ii_eff = ii_q;
    ctx_last = CTXW'(ii_eff - IIW'(1));
  end

  always_comb begin
    ii_d = ii_ok ? ii_val : ii_q;
    if (!run_en)               ctx_d = '0;
    else if (ctx_q == ctx_last) ctx_d = '0;
    else                       ctx_d = ctx_q + CTXW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ii_q  <= IIW'(1);
      ctx_q <= '0;
    end else begin
      ii_q  <= ii_d;
      ctx_q <= ctx_d;
    end
  end
endmodule

// File: rtl/dual_omega_router.sv
module dual_omega_router #(
  parameter int DW     = 16,
  parameter int NPORT  = 16,
  parameter int MAXCTX = 8,
  localparam int STAGES = $clog2(NPORT) / 2,
  localparam int CTXW   = (MAXCTX > 1) ? $clog2(MAXCTX) : 1,
  localparam int STW    = (STAGES > 1) ? $clog2(STAGES) : 1,
  localparam int PW     = $clog2(NPORT),
  localparam int IIW    = $clog2(MAXCTX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic                 cfg_we,
  input  logic [CTXW-1:0]      cfg_ctx,
  input  logic                 cfg_net,
  input  logic [STW-1:0]       cfg_stage,
  input  logic [PW-1:0]        cfg_port,
  input  logic [1:0]           cfg_sel,
  input  logic                 ii_we,
  input  logic [IIW-1:0]       ii_val,
  input  logic [NPORT*DW-1:0]  fu_res,
  output logic [NPORT*DW-1:0]  opa_data,
  output logic [NPORT*DW-1:0]  opb_data,
  output logic [CTXW-1:0]      cur_ctx
);
  logic [STAGES*NPORT*2-1:0] sel_a, sel_b;
  logic [NPORT*DW-1:0]       route_a, route_b;
  logic [NPORT*DW-1:0]       opa_q, opb_q;
  logic [IIW-1:0]            ii_eff;

  dor_ctx_seq #(
    .NPORT(NPORT), .STAGES(STAGES), .MAXCTX(MAXCTX), .CTXW(CTXW),
    .STW(STW), .PW(PW), .IIW(IIW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .cfg_we(cfg_we), .cfg_ctx(cfg_ctx), .cfg_net(cfg_net),
    .cfg_stage(cfg_stage), .cfg_port(cfg_port), .cfg_sel(cfg_sel),
    .ii_we(ii_we), .ii_val(ii_val),
    .sel_a(sel_a), .sel_b(sel_b), .ctx_q(cur_ctx), .ii_eff(ii_eff)
  );

  dor_omega #(.DW(DW), .NPORT(NPORT), .STAGES(STAGES)) u_net_a (
    .net_in(fu_res), .net_sel(sel_a), .net_out(route_a)
  );

  dor_omega #(.DW(DW), .NPORT(NPORT), .STAGES(STAGES)) u_net_b (
    .net_in(fu_res), .net_sel(sel_b), .net_out(route_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
    end else begin
      opa_q <= route_a;
      opb_q <= route_b;
    end
  end

  assign opa_data = opa_q;
  assign opb_data = opb_q;
endmodule

// File: rtl/dual_omega_router_chk.sv
module dual_omega_router_chk #(
  parameter int CTXW   = 3,
  parameter int IIW    = 4,
  parameter int MAXCTX = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run_en,
  input logic [CTXW-1:0] cur_ctx,
  input logic [IIW-1:0]  ii_eff
);
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_en) |-> cur_ctx == '0);

  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_en) && cur_ctx != '0) |-> cur_ctx == CTXW'($past(cur_ctx) + 1'b1));

  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_en) && $past(cur_ctx) == CTXW'(ii_eff - 1'b1)) |-> cur_ctx == '0);

  a_r8_ii_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ii_eff != '0) && (int'(ii_eff) <= MAXCTX));

  a_r9_ii_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_en) |-> $stable(ii_eff));
endmodule

bind dual_omega_router dual_omega_router_chk #(
  .CTXW(CTXW), .IIW(IIW), .MAXCTX(MAXCTX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .cur_ctx(cur_ctx), .ii_eff(ii_eff)
);

// File: tb/sim_dual_omega_router.sv
module sim_dual_omega_router;
  localparam int DW = 16, NP = 16, MC = 8, ST = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, cfg_we = 1'b0, cfg_net = 1'b0, ii_we = 1'b0;
  logic [2:0] cfg_ctx = '0;
  logic [0:0] cfg_stage = '0;
  logic [3:0] cfg_port = '0, ii_val = '0;
  logic [1:0] cfg_sel = '0;
  logic [NP*DW-1:0] fu_res = '0;
  logic [NP*DW-1:0] opa_data, opb_data;
  logic [2:0] cur_ctx;

  always #10 clk = ~clk;

  dual_omega_router u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_we(cfg_we),
    .cfg_ctx(cfg_ctx), .cfg_net(cfg_net), .cfg_stage(cfg_stage),
    .cfg_port(cfg_port), .cfg_sel(cfg_sel), .ii_we(ii_we), .ii_val(ii_val),
    .fu_res(fu_res), .opa_data(opa_data), .opb_data(opb_data), .cur_ctx(cur_ctx)
  );

  int n_vec = 0, n_bad = 0;
  int msel [MC][2][ST][NP];
  int m_ctx = 0, m_ii = 1;
  logic [NP*DW-1:0] exp_a, exp_b;

  function automatic int eff_ii(int v);
    if (v == 0) return 1;
    if (v > MC) return MC;
    return v;
  endfunction

  // trace a final output port back to its source result port
  function automatic int src_of(int net, int c, int p);
    int q = p;
    for (int k = ST - 1; k >= 0; k--) begin
      int idx = (q / 4) * 4 + msel[c][net][k][q];
      if (k == 0) return idx;
      q = (idx % (NP / 4)) * 4 + idx / (NP / 4);
    end
    return 0;
  endfunction

  task automatic rand_src();
    for (int p = 0; p < NP; p++) fu_res[p*DW +: DW] = DW'($urandom);
  endtask

  task automatic step(string tag);
    for (int p = 0; p < NP; p++) begin
      exp_a[p*DW +: DW] = fu_res[src_of(0, m_ctx, p)*DW +: DW];
      exp_b[p*DW +: DW] = fu_res[src_of(1, m_ctx, p)*DW +: DW];
    end
    if (cfg_we && !run_en) msel[cfg_ctx][cfg_net][cfg_stage][cfg_port] = int'(cfg_sel);
    if (run_en) m_ctx = (m_ctx == eff_ii(m_ii) - 1) ? 0 : m_ctx + 1;
    else m_ctx = 0;
    if (ii_we && !run_en) m_ii = int'(ii_val);
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (opa_data !== exp_a || opb_data !== exp_b || int'(cur_ctx) != m_ctx) begin
      n_bad++;
      $display("FAIL %s: opa=%h opb=%h ctx=%0d expected opa=%h opb=%h ctx=%0d",
               tag, opa_data, opb_data, cur_ctx, exp_a, exp_b, m_ctx);
    end
  endtask

  task automatic wr_sel(int c, int net, int k, int p, int s, string tag);
    cfg_we = 1'b1; cfg_ctx = 3'(c); cfg_net = net[0]; cfg_stage = 1'(k);
    cfg_port = 4'(p); cfg_sel = 2'(s);
    rand_src();
    step(tag);
    cfg_we = 1'b0;
  endtask

  task automatic wr_ii(int v, string tag);
    ii_we = 1'b1; ii_val = 4'(v);
    step(tag);
    ii_we = 1'b0;
  endtask

  task automatic fill_ctx(int c, string tag);
    for (int n = 0; n < 2; n++)
      for (int k = 0; k < ST; k++)
        for (int p = 0; p < NP; p++) wr_sel(c, n, k, p, int'($urandom % 4), tag);
  endtask

  task automatic run(int cycles, string tag);
    for (int i = 0; i < cycles; i++) begin
      rand_src();
      step(tag);
    end
  endtask

  initial begin
    for (int c = 0; c < MC; c++) for (int n = 0; n < 2; n++)
      for (int k = 0; k < ST; k++) for (int p = 0; p < NP; p++) msel[c][n][k][p] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    n_vec++;  // R1 reset state
    if (opa_data !== '0 || opb_data !== '0 || cur_ctx !== 3'd0) begin
      n_bad++;
      $display("FAIL R1: opa=%h opb=%h ctx=%0d expected zeros", opa_data, opb_data, cur_ctx);
    end
    run(3, "R1");                         // all selects zero after reset
    fill_ctx(0, "R10");                   // each write steers the next edge
    run(12, "R3");                        // shuffle and switch selection
    run(6, "R5");
    // multicast: every output of a switch takes the same input
    for (int n = 0; n < 2; n++) for (int k = 0; k < ST; k++)
      for (int p = 0; p < NP; p++) wr_sel(0, n, k, p, (p / 4 + n) % 4, "R4");
    run(6, "R4");
    fill_ctx(0, "R2");
    wr_ii(3, "R7");
    fill_ctx(1, "R5");
    fill_ctx(2, "R2");
    run_en = 1'b1;
    run(20, "R7");
    run(4, "R6");
    // writes while running must be ignored
    cfg_we = 1'b1; cfg_ctx = 3'd1; cfg_net = 1'b0; cfg_stage = 1'b1; cfg_port = 4'd5;
    cfg_sel = 2'(msel[1][0][1][5] + 1);
    ii_we = 1'b1; ii_val = 4'd6;
    run(8, "R9");
    cfg_we = 1'b0; ii_we = 1'b0;
    run(9, "R9");
    run_en = 1'b0;
    run(2, "R7");
    wr_ii(0, "R8");
    run_en = 1'b1;
    run(5, "R8");
    run_en = 1'b0;
    for (int c = 3; c < MC; c++) fill_ctx(c, "R2");
    wr_ii(15, "R8");
    run_en = 1'b1;
    run(20, "R8");
    run_en = 1'b0;
    wr_ii(8, "R8");
    run_en = 1'b1;
    run(17, "R7");
    run_en = 1'b0;
    run(2, "R7");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule